// File: doc/BRIEF.md
# Residual Transform Stage Sequencer

This block times the four stages that turn one decoded block of residual coefficients back into sample residuals. The stages are rescale (inverse quantisation), a first-pass 1-D inverse transform, a second-pass 2-D inverse transform, and rounding. Each stage owns a 3-bit down-counter. A counter loads 4 when its stage is launched and then falls by one per clock to 0, so the values 4 and 1 mark the first and last cycles of a stage. The stage order depends on the kind of residual block. The next stage is launched from a particular value of the previous stage's counter, so two stages can overlap by one cycle or by most of a stage.

A sequence starts when the coefficient decoder signals the end of a block and its state is not the coefficient-count lookup state. The kind code is sorted into one of three sequence classes at that moment, and the class is held for the whole sequence. Each stage also has an active flag that a clock-gating cell can use. The block raises a one-cycle done pulse when the last stage of the selected sequence has drained.

The controller is a four-state machine:
- `SQ_IDLE`: waiting for a start.
- `SQ_AC`: an AC sequence is running.
- `SQ_LDC`: a luma 16x16 DC sequence is running.
- `SQ_CDC`: a chroma DC sequence is running.

Its transitions are:
- start-accept: `SQ_IDLE` moves to the state of the class decoded in the start cycle.
- sequence-end: any running state moves back to `SQ_IDLE` in the cycle in which its final stage counter reads 1.

Top module: `resid_xform_seq`

## Requirements
- R1: A synchronous active-high reset sets all four counters to 0, clears the active flags and done, and returns the controller to idle, including in the middle of a sequence.
- R2: A sequence starts only in a cycle where `coef_end_i` is 1, `dec_state_i` is not 4'b0010, `kind_i` is a listed code and the block is idle. With `dec_state_i` = 4'b0010 nothing is launched.
- R3: For the AC kinds (4'b0011 luma 16x16 AC, 4'b0110 plain luma, 4'b1100 chroma AC Cb, 4'b1101 chroma AC Cr), the stages run in this order:
  - rescale, launched in the start cycle;
  - 1-D, launched in the cycle in which the rescale counter is 4;
  - 2-D, launched in the cycle in which the 1-D counter is 1;
  - rounding, launched in the cycle in which the 2-D counter is 4.
- R4: For luma 16x16 DC (4'b0001), the stages run in this order, and the rounding counter stays 0:
  - 1-D, launched in the start cycle;
  - 2-D, launched in the cycle in which the 1-D counter is 1;
  - rescale, launched in the cycle in which the 2-D counter is 4.
- R5: For chroma DC (4'b0101 Cb, 4'b0100 Cr), the stages run in this order, and the 2-D and rounding counters stay 0:
  - 1-D, launched in the start cycle;
  - rescale, launched in the cycle in which the 1-D counter is 1.
- R6: A launched counter reads 4 in the next cycle and then falls by one per clock until it reaches 0.
- R7: The active flag of a stage is 1 exactly when that stage's counter is nonzero or its launch condition is true in that cycle. The flag bits are: bit 0 rescale, bit 1 1-D, bit 2 2-D, bit 3 rounding.
- R8: `done_o` is 1 for exactly one cycle: the first cycle in which the last stage of the sequence reads 0 again.
- R9: Changes on `kind_i` after the start cycle do not alter the running sequence.
- R10: Start pulses while a sequence is running are ignored. A start in the cycle in which done is high is accepted.
- R11: Kind codes that are not listed (for example 4'b0000 or 4'b1111) launch no stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_end_i | input | 1 | Pulse: coefficient decoding of a block finished |
| dec_state_i | input | 4 | Coefficient decoder state; 4'b0010 is the count lookup state |
| kind_i | input | 4 | Residual kind code |
| rsc_cnt_o | output | 3 | Rescale stage counter |
| d1_cnt_o | output | 3 | 1-D transform stage counter |
| d2_cnt_o | output | 3 | 2-D transform stage counter |
| rnd_cnt_o | output | 3 | Rounding stage counter |
| stage_act_o | output | 4 | Per-stage active flags (bit 0 rescale, bit 1 1-D, bit 2 2-D, bit 3 rounding) |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
A wrong sequence class, or a lost hand-off between stages, shows at the counter ports within one cycle. Either a counter that should have loaded 4 stays at 0, or a counter that belongs to no stage of the class leaves 0. A controller that leaves its running state at the wrong time shows as a done pulse in the wrong cycle. It also shows as a start that is wrongly accepted or refused in the following cycles. The reference model predicts every counter, flag and done value from the kind's launch timeline and compares them on every clock. It covers all seven kinds, refused starts, back-to-back sequences and a reset in the middle of a sequence.

// File: rtl/rts_pkg.sv
`timescale 1ns/1ps
package rts_pkg;

    localparam int NSTG    = 4;
    localparam int STG_RSC = 0;
    localparam int STG_D1  = 1;
    localparam int STG_D2  = 2;
    localparam int STG_RND = 3;
    localparam int KIND_W  = 4;

    localparam logic [KIND_W-1:0] KC_LUMA_DC   = 4'b0001;
    localparam logic [KIND_W-1:0] KC_CHR_DC_B  = 4'b0101;
    localparam logic [KIND_W-1:0] KC_CHR_DC_R  = 4'b0100;
    localparam logic [KIND_W-1:0] KC_LUMA16_AC = 4'b0011;
    localparam logic [KIND_W-1:0] KC_LUMA_PL   = 4'b0110;
    localparam logic [KIND_W-1:0] KC_CHR_AC_B  = 4'b1100;
    localparam logic [KIND_W-1:0] KC_CHR_AC_R  = 4'b1101;
    localparam logic [KIND_W-1:0] DEC_COUNT_LUT = 4'b0010;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_AC   = 2'd1,
        CLS_LDC  = 2'd2,
        CLS_CDC  = 2'd3
    } seq_cls_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_AC   = 2'd1,
        SQ_LDC  = 2'd2,
        SQ_CDC  = 2'd3
    } seq_st_e;

    function automatic seq_cls_e classify(input logic [KIND_W-1:0] k);
        seq_cls_e c;
        case (k)
            KC_LUMA16_AC, KC_LUMA_PL,
            KC_CHR_AC_B, KC_CHR_AC_R:  c = CLS_AC;
            KC_LUMA_DC:                c = CLS_LDC;
            KC_CHR_DC_B, KC_CHR_DC_R:  c = CLS_CDC;
            default:                   c = CLS_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rts_stage_ctr.sv
`timescale 1ns/1ps
module rts_stage_ctr #(
    parameter int RUN_LEN = 4,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             act_o
);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (launch_i)
            cnt_q <= LOAD_V;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o = cnt_q;
    assign act_o = launch_i || (cnt_q != '0);

    // R6
    load_val_chk: assert property (@(posedge clk) disable iff (rst)
        launch_i |=> cnt_q == LOAD_V);

    // R6
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!launch_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/rts_launch_dec.sv
`timescale 1ns/1ps
module rts_launch_dec
    import rts_pkg::*;
#(
    parameter int RUN_LEN = 4,
    parameter int CNT_W   = 3
) (
    input  seq_st_e                       state_i,
    input  logic                          fire_i,
    input  seq_cls_e                      fire_cls_i,
    input  logic [NSTG-1:0][CNT_W-1:0]    cnt_i,
    output logic [NSTG-1:0]               launch_o,
    output logic                          seq_end_o
);
    localparam logic [CNT_W-1:0] FIRST_V = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(1);

    logic rsc_first, d1_last, d2_first;

    assign rsc_first = (cnt_i[STG_RSC] == FIRST_V);
    assign d1_last   = (cnt_i[STG_D1]  == LAST_V);
    assign d2_first  = (cnt_i[STG_D2]  == FIRST_V);

    always_comb begin
        launch_o  = '0;
        seq_end_o = 1'b0;
        unique case (state_i)
            SQ_IDLE: begin
                if (fire_i) begin
                    launch_o[STG_RSC] = (fire_cls_i == CLS_AC);
                    launch_o[STG_D1]  = (fire_cls_i == CLS_LDC) || (fire_cls_i == CLS_CDC);
                end
            end
            SQ_AC: begin
                launch_o[STG_D1]  = rsc_first;
                launch_o[STG_D2]  = d1_last;
                launch_o[STG_RND] = d2_first;
                seq_end_o         = (cnt_i[STG_RND] == LAST_V);
            end
            SQ_LDC: begin
                launch_o[STG_D2]  = d1_last;
                launch_o[STG_RSC] = d2_first;
                seq_end_o         = (cnt_i[STG_RSC] == LAST_V);
            end
            SQ_CDC: begin
                launch_o[STG_RSC] = d1_last;
                seq_end_o         = (cnt_i[STG_RSC] == LAST_V);
            end
        endcase
    end

endmodule

// File: rtl/rts_seq_fsm.sv
`timescale 1ns/1ps
module rts_seq_fsm
    import rts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              seq_end_i,
    output seq_st_e           state_o,
    output logic              fire_o,
    output seq_cls_e          fire_cls_o,
    output logic              done_o
);
    seq_st_e  state_q, state_d;
    seq_cls_e in_cls;
    logic     fire;
    logic     done_q;

    assign in_cls = classify(kind_i);
    assign fire   = (state_q == SQ_IDLE) && start_i && (in_cls != CLS_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= seq_end_i && (state_q != SQ_IDLE);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (fire) begin
                    unique case (in_cls)
                        CLS_AC:   state_d = SQ_AC;
                        CLS_LDC:  state_d = SQ_LDC;
                        CLS_CDC:  state_d = SQ_CDC;
                        CLS_NONE: state_d = SQ_IDLE;
                    endcase
                end
            end
            SQ_AC, SQ_LDC, SQ_CDC: begin
                if (seq_end_i)
                    state_d = SQ_IDLE;
            end
        endcase
    end

    assign state_o    = state_q;
    assign fire_o     = fire;
    assign fire_cls_o = in_cls;
    assign done_o     = done_q;

    // R2
    start_taken_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> state_q != SQ_IDLE);

    // R9
    class_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE && !seq_end_i) |=> state_q == $past(state_q));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/resid_xform_seq.sv
`timescale 1ns/1ps
module resid_xform_seq
    import rts_pkg::*;
#(
    parameter int RUN_LEN = 4,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              coef_end_i,
    input  logic [KIND_W-1:0] dec_state_i,
    input  logic [KIND_W-1:0] kind_i,
    output logic [CNT_W-1:0]  rsc_cnt_o,
    output logic [CNT_W-1:0]  d1_cnt_o,
    output logic [CNT_W-1:0]  d2_cnt_o,
    output logic [CNT_W-1:0]  rnd_cnt_o,
    output logic [NSTG-1:0]   stage_act_o,
    output logic              done_o
);
    seq_st_e                    state;
    seq_cls_e                   fire_cls;
    logic                       fire;
    logic                       start;
    logic                       seq_end;
    logic [NSTG-1:0]            launch;
    logic [NSTG-1:0][CNT_W-1:0] cnt_all;

    assign start = coef_end_i && (dec_state_i != DEC_COUNT_LUT);

    rts_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .kind_i    (kind_i),
        .seq_end_i (seq_end),
        .state_o   (state),
        .fire_o    (fire),
        .fire_cls_o(fire_cls),
        .done_o    (done_o)
    );

    rts_launch_dec #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_dec (
        .state_i   (state),
        .fire_i    (fire),
        .fire_cls_i(fire_cls),
        .cnt_i     (cnt_all),
        .launch_o  (launch),
        .seq_end_o (seq_end)
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        rts_stage_ctr #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .launch_i(launch[g]),
            .cnt_o   (cnt_all[g]),
            .act_o   (stage_act_o[g])
        );
    end

    assign rsc_cnt_o = cnt_all[STG_RSC];
    assign d1_cnt_o  = cnt_all[STG_D1];
    assign d2_cnt_o  = cnt_all[STG_D2];
    assign rnd_cnt_o = cnt_all[STG_RND];

    // R4
    ldc_no_round_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_LDC || state == SQ_CDC) |-> rnd_cnt_o == '0);

    // R5
    cdc_no_twod_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_CDC) |-> d2_cnt_o == '0);

    // R2
    lut_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && dec_state_i == DEC_COUNT_LUT) |-> launch == '0);

endmodule

// File: tb/resid_xform_seq_test.sv
`timescale 1ns/1ps
module resid_xform_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coef_end = 1'b0;
    logic [3:0] dec_state = 4'd0;
    logic [3:0] kind = 4'd0;
    logic [2:0] rsc_cnt, d1_cnt, d2_cnt, rnd_cnt;
    logic [3:0] act;
    logic       done;

    always #2.5 clk = ~clk;

    resid_xform_seq uut (
        .clk        (clk),
        .rst        (rst),
        .coef_end_i (coef_end),
        .dec_state_i(dec_state),
        .kind_i     (kind),
        .rsc_cnt_o  (rsc_cnt),
        .d1_cnt_o   (d1_cnt),
        .d2_cnt_o   (d2_cnt),
        .rnd_cnt_o  (rnd_cnt),
        .stage_act_o(act),
        .done_o     (done)
    );

    int    n_cmp  = 0;
    int    n_fail = 0;
    int    cyc    = 0;
    string scen   = "R1";

    // reference model state: absolute launch cycle per stage
    int la [4];
    int end_cyc  = -1000;
    int done_cyc = -1000;
    logic rst_prev = 1'b1;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s/%s cycle %0d: %s actual %0d expected %0d", scen, tag, cyc, what, got, exp);
        end
    endtask

    // 0 none, 1 AC, 2 luma DC, 3 chroma DC
    function automatic int kind_class(input logic [3:0] k);
        if (k == 4'b0011 || k == 4'b0110 || k == 4'b1100 || k == 4'b1101) return 1;
        if (k == 4'b0001) return 2;
        if (k == 4'b0101 || k == 4'b0100) return 3;
        return 0;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 4; s++) la[s] = -1000;
        end_cyc  = -1000;
        done_cyc = -1000;
    endtask

    task automatic model_check(input logic ce, input logic [3:0] ds, input logic [3:0] kd);
        int exp_cnt [4];
        int exp_act;
        int exp_done;
        int c;
        int last;
        if (rst_prev) model_clear();
        exp_done = (cyc == done_cyc) ? 1 : 0;
        c = kind_class(kd);
        if (!rst && ce && ds != 4'b0010 && c != 0 && cyc >= end_cyc) begin
            for (int s = 0; s < 4; s++) la[s] = -1000;
            if (c == 1) begin          // R3 order: rescale, 1-D, 2-D, rounding
                la[0] = cyc;
                la[1] = la[0] + 1;     // rescale counter at 4
                la[2] = la[1] + 4;     // 1-D counter at 1
                la[3] = la[2] + 1;     // 2-D counter at 4
                last  = la[3];
            end else if (c == 2) begin // R4 order: 1-D, 2-D, rescale
                la[1] = cyc;
                la[2] = la[1] + 4;
                la[0] = la[2] + 1;
                last  = la[0];
            end else begin             // R5 order: 1-D, rescale
                la[1] = cyc;
                la[0] = la[1] + 4;
                last  = la[0];
            end
            end_cyc  = last + 5;
            done_cyc = end_cyc;
        end
        exp_act = 0;
        for (int s = 0; s < 4; s++) begin
            exp_cnt[s] = (cyc > la[s] && cyc <= la[s] + 4) ? (la[s] + 5 - cyc) : 0;
            if (exp_cnt[s] != 0 || cyc == la[s]) exp_act |= (1 << s);
        end
        chk("R6", "rescale count", int'(rsc_cnt), exp_cnt[0]);
        chk("R6", "1-D count",     int'(d1_cnt),  exp_cnt[1]);
        chk("R6", "2-D count",     int'(d2_cnt),  exp_cnt[2]);
        chk("R6", "round count",   int'(rnd_cnt), exp_cnt[3]);
        chk("R7", "active flags",  int'(act),     exp_act);
        chk("R8", "done",          int'(done),    exp_done);
        rst_prev = rst;
    endtask

    task automatic step(input logic ce, input logic [3:0] ds, input logic [3:0] kd, input logic r);
        @(posedge clk);
        cyc++;
        #1;
        coef_end  = ce;
        dec_state = ds;
        kind      = kd;
        rst       = r;
        @(negedge clk);
        model_check(ce, ds, kd);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'd0, 4'd0, 1'b0);
    endtask

    task automatic run_kind(input logic [3:0] kd, input int tail);
        step(1'b1, 4'd0, kd, 1'b0);
        idle(tail);
    endtask

    initial begin : watchdog
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        // R1: reset state after several clocked resets
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "rescale count", int'(rsc_cnt), 0);
        chk("R1", "1-D count",     int'(d1_cnt),  0);
        chk("R1", "2-D count",     int'(d2_cnt),  0);
        chk("R1", "round count",   int'(rnd_cnt), 0);
        chk("R1", "active flags",  int'(act),     0);
        chk("R1", "done",          int'(done),    0);
        idle(2);

        // R3: all four AC kinds
        scen = "R3"; run_kind(4'b0110, 13);
        run_kind(4'b0011, 13);
        run_kind(4'b1100, 13);
        run_kind(4'b1101, 13);
        // R4: luma 16x16 DC
        scen = "R4"; run_kind(4'b0001, 12);
        // R5: both chroma DC kinds
        scen = "R5"; run_kind(4'b0101, 11);
        run_kind(4'b0100, 11);

        // R2: count lookup state blocks the start
        scen = "R2";
        step(1'b1, 4'b0010, 4'b0110, 1'b0);
        idle(4);
        step(1'b1, 4'b0010, 4'b0001, 1'b0);
        idle(4);

        // R11: unlisted kind codes
        scen = "R11";
        step(1'b1, 4'd0, 4'b0000, 1'b0);
        idle(3);
        step(1'b1, 4'd0, 4'b1111, 1'b0);
        idle(3);

        // R9 and R10: kind changes and start pulses during a run
        scen = "R9";
        step(1'b1, 4'd0, 4'b0101, 1'b0);
        step(1'b0, 4'd0, 4'b0110, 1'b0);
        step(1'b0, 4'd0, 4'b0001, 1'b0);
        scen = "R10";
        step(1'b1, 4'd0, 4'b1101, 1'b0);
        step(1'b1, 4'd0, 4'b0001, 1'b0);
        idle(8);

        // R10: start accepted in the done cycle (AC done 11 cycles after start)
        step(1'b1, 4'd0, 4'b0110, 1'b0);
        idle(10);
        step(1'b1, 4'd0, 4'b0001, 1'b0);
        idle(12);

        // R1: reset in the middle of a sequence
        scen = "R1";
        step(1'b1, 4'd0, 4'b1100, 1'b0);
        idle(3);
        step(1'b0, 4'd0, 4'd0, 1'b1);
        step(1'b0, 4'd0, 4'd0, 1'b0);
        idle(3);
        scen = "R3";
        run_kind(4'b0011, 13);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule